// File: doc/BRIEF.md
# Configuration-Mode Unlock Register File

This block is the configuration port of a peripheral controller. A host reaches it through two 8-bit I/O addresses: the index port at the block's base address and the data port one address above it. A strap input selects which of two base addresses the block answers on, 0x2E or 0x4E. While the block is locked, the index port only listens for a four-byte key, and the data port is inert.

After the key is accepted, the host writes a register number to the index port and reads or writes that register through the data port. Global registers give the chip identity, a logical-device select, and the flash control flags. Per-device registers are banked behind the device select. Each device has an activate bit. One device, the flash device, also holds the 16-bit I/O base of the serial flash controller. Writing the exit code to the exit register locks the space again.

The flag fields, the flash I/O base and the activate bits are brought out as outputs so that neighbouring logic can use them.

Top module: `cfgu_unlock_regfile`

## Requirements
- R1: Writing 0x87, 0x01, 0x55 and then a fourth key byte to the index port, in that order, opens configuration mode (`cfg_open`=1). The fourth byte is 0x55 when `strap_alt_base`=0 (base 0x2E) and 0xAA when `strap_alt_base`=1 (base 0x4E). The other value does not open.
- R2: A key byte that does not match the expected byte restarts the match. If that byte is 0x87, it counts as the first key byte.
- R3: While locked, a read of the data port or the index port returns 0xFF, and writes to the data port change no register.
- R4: Only the strapped pair responds. Reads of any other address return 0xFF. Writes to any other address, including key bytes, have no effect.
- R5: Registers 0x20 and 0x21 read 0x87 and 0x16 (the ID 0x8716). They are read-only.
- R6: Writing 0x02 to register 0x02 closes configuration mode. Any other value written there has no effect.
- R7: Register 0x07 holds the logical-device number, reads back as written, and selects the bank seen by the per-device registers.
- R8: With device 7 selected, registers 0x64 and 0x65 hold the high and low bytes of `flash_io_base` (reset value 0x0820). With any other device selected, those indexes read 0x00 and writes to them are ignored.
- R9: Register 0x24 holds the flash flags. Bits 5:0 are writable and bits 7:6 read 0. The fields are: bit 0 `flash_suspend`, bits 3:1 `flash_seg_en`, bit 4 `flash_lpc_wr_en`, bit 5 `flash_pin_sel`.
- R10: Register 0x30 bit 0 is the activate bit of the selected device, kept separately for each device and shown on `ldn_active[n]`.
- R11: Read data appears on `io_rdata` in the cycle after the read strobe and holds until the next read. While open, the index port reads back the current index, and unmapped indexes read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt_base | input | 1 | 0: base 0x2E, 1: base 0x4E |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered read byte |
| cfg_open | output | 1 | Configuration mode is open |
| flash_io_base | output | 16 | Flash controller I/O base |
| flash_seg_en | output | 3 | Flash address segment enables |
| flash_lpc_wr_en | output | 1 | Host writes to flash enabled |
| flash_pin_sel | output | 1 | Flash pin select |
| flash_suspend | output | 1 | Flash suspend flag |
| ldn_active | output | 8 | Activate bit per logical device |

## Verification
Every write takes effect at the clock edge that samples its strobe. `cfg_open`, the flag outputs, `flash_io_base` and `ldn_active` therefore show the new value one cycle after the strobe. The read byte is registered on the strobe edge, so it too is due one cycle later. The bench drives each strobe on a falling edge and clears it on the next falling edge, where it samples. That point falls after exactly one rising edge, and every expected value is due there. The sweeps cover every flag byte, every device bank, both straps, and key streams that break off and restart.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;
   // register indexes the host selects through the index port
   localparam logic [7:0] IDX_EXIT     = 8'h02;
   localparam logic [7:0] IDX_LDN      = 8'h07;
   localparam logic [7:0] IDX_ID_HI    = 8'h20;
   localparam logic [7:0] IDX_ID_LO    = 8'h21;
   localparam logic [7:0] IDX_FLAGS    = 8'h24;
   localparam logic [7:0] IDX_ACT      = 8'h30;
   localparam logic [7:0] IDX_FBASE_HI = 8'h64;
   localparam logic [7:0] IDX_FBASE_LO = 8'h65;

   localparam logic [7:0] EXIT_CODE    = 8'h02;
   localparam logic [7:0] KEY_B0       = 8'h87;
   localparam logic [7:0] KEY_B1       = 8'h01;
   localparam logic [7:0] KEY_B2       = 8'h55;
   localparam logic [7:0] FLAG_MASK    = 8'h3F;
   localparam logic [7:0] BUS_IDLE     = 8'hFF;

   typedef enum logic [1:0] {
      K_IDLE = 2'd0,
      K_GOT1 = 2'd1,
      K_GOT2 = 2'd2,
      K_GOT3 = 2'd3
   } key_state_e;
endpackage

// File: rtl/cfgu_key_fsm.sv
module cfgu_key_fsm
   import cfgu_pkg::*;
#(
   parameter logic [7:0] KEY3_LO = 8'h55,
   parameter logic [7:0] KEY3_HI = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       alt_base,
   input  logic       byte_wr,
   input  logic [7:0] byte_val,
   input  logic       exit_req,
   output logic       open_o
);
   key_state_e state_q;
   logic [7:0] key3;
   logic [7:0] expect_b;
   logic       match;

   assign key3 = alt_base ? KEY3_HI : KEY3_LO;

   always_comb begin
      case (state_q)
         K_IDLE:  expect_b = KEY_B0;
         K_GOT1:  expect_b = KEY_B1;
         K_GOT2:  expect_b = KEY_B2;
         default: expect_b = key3;
      endcase
   end

   assign match = (byte_val == expect_b);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= K_IDLE;
         open_o  <= 1'b0;
      end else if (open_o) begin
         state_q <= K_IDLE;
         if (exit_req) open_o <= 1'b0;
      end else if (byte_wr) begin
         if (match) begin
            if (state_q == K_GOT3) begin
               open_o  <= 1'b1;
               state_q <= K_IDLE;
            end else begin
               state_q <= key_state_e'(state_q + 2'd1);
            end
         end else begin
            // a broken stream may itself start a new key
            state_q <= (byte_val == KEY_B0) ? K_GOT1 : K_IDLE;
         end
      end
   end

   AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_o) |-> $past(byte_wr && byte_val == key3)); // R1

   AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (open_o && exit_req) |=> !open_o); // R6

   AST_NO_OPEN_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_o && !byte_wr) |=> !open_o); // R4
endmodule

// File: rtl/cfgu_global_regs.sv
module cfgu_global_regs
   import cfgu_pkg::*;
#(
   parameter logic [15:0] CHIP_ID = 16'h8716
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       open_i,
   input  logic       idx_wr,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   output logic [7:0] idx_q,
   output logic [7:0] ldn_q,
   output logic [7:0] flags_q,
   output logic       exit_req,
   output logic       rd_hit,
   output logic [7:0] rd_val
);
   logic wr_en;
   assign wr_en    = open_i & data_wr;
   assign exit_req = wr_en & (idx_q == IDX_EXIT) & (wdata == EXIT_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= 8'h00;
         ldn_q   <= 8'h00;
         flags_q <= 8'h00;
      end else begin
         if (!open_i)                idx_q <= 8'h00;
         else if (idx_wr)            idx_q <= wdata;
         if (wr_en) begin
            case (idx_q)
               IDX_LDN:   ldn_q   <= wdata;
               IDX_FLAGS: flags_q <= wdata & FLAG_MASK;
               default:   ;
            endcase
         end
      end
   end

   always_comb begin
      rd_hit = 1'b1;
      case (idx_q)
         IDX_LDN:   rd_val = ldn_q;
         IDX_ID_HI: rd_val = CHIP_ID[15:8];
         IDX_ID_LO: rd_val = CHIP_ID[7:0];
         IDX_FLAGS: rd_val = flags_q;
         default: begin
            rd_hit = 1'b0;
            rd_val = 8'h00;
         end
      endcase
   end

   AST_FLAGS_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_i && $past(!open_i)) |-> $stable(flags_q)); // R3

   AST_LDN_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_i && $past(!open_i)) |-> $stable(ldn_q)); // R7
endmodule

// File: rtl/cfgu_ldn_bank.sv
module cfgu_ldn_bank
   import cfgu_pkg::*;
#(
   parameter int          NUM_LDN   = 8,
   parameter int          FLASH_LDN = 7,
   parameter logic [15:0] FBASE_RST = 16'h0820
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               open_i,
   input  logic               data_wr,
   input  logic [7:0]         idx,
   input  logic [7:0]         ldn,
   input  logic [7:0]         wdata,
   output logic [NUM_LDN-1:0] act_q,
   output logic [15:0]        fbase_q,
   output logic               rd_hit,
   output logic [7:0]         rd_val
);
   localparam logic [7:0] FLASH_SEL = 8'(FLASH_LDN);

   logic wr_en;
   logic sel_flash;
   logic sel_valid;
   logic act_rd;

   assign wr_en     = open_i & data_wr;
   assign sel_flash = (ldn == FLASH_SEL);

   for (genvar g = 0; g < NUM_LDN; g++) begin : g_dev
      logic hit;
      assign hit = wr_en & (idx == IDX_ACT) & (ldn == 8'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)   act_q[g] <= 1'b0;
         else if (hit) act_q[g] <= wdata[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fbase_q <= FBASE_RST;
      end else if (wr_en && sel_flash) begin
         if (idx == IDX_FBASE_HI) fbase_q[15:8] <= wdata;
         if (idx == IDX_FBASE_LO) fbase_q[7:0]  <= wdata;
      end
   end

   always_comb begin
      act_rd    = 1'b0;
      sel_valid = 1'b0;
      for (int i = 0; i < NUM_LDN; i++) begin
         if (ldn == 8'(i)) begin
            act_rd    = act_q[i];
            sel_valid = 1'b1;
         end
      end
   end

   always_comb begin
      rd_hit = 1'b0;
      rd_val = 8'h00;
      if (idx == IDX_ACT && sel_valid) begin
         rd_hit = 1'b1;
         rd_val = {7'b0, act_rd};
      end else if (sel_flash && idx == IDX_FBASE_HI) begin
         rd_hit = 1'b1;
         rd_val = fbase_q[15:8];
      end else if (sel_flash && idx == IDX_FBASE_LO) begin
         rd_hit = 1'b1;
         rd_val = fbase_q[7:0];
      end
   end

   AST_FBASE_ONLY_FLASH_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_flash |=> $stable(fbase_q)); // R8

   AST_ACT_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !open_i |=> $stable(act_q)); // R10
endmodule

// File: rtl/cfgu_unlock_regfile.sv
module cfgu_unlock_regfile
   import cfgu_pkg::*;
#(
   parameter logic [15:0] BASE_LO   = 16'h002E,
   parameter logic [15:0] BASE_HI   = 16'h004E,
   parameter logic [7:0]  KEY3_LO   = 8'h55,
   parameter logic [7:0]  KEY3_HI   = 8'hAA,
   parameter logic [15:0] CHIP_ID   = 16'h8716,
   parameter int          NUM_LDN   = 8,
   parameter int          FLASH_LDN = 7,
   parameter logic [15:0] FBASE_RST = 16'h0820
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strap_alt_base,
   input  logic [15:0]        io_addr,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [7:0]         io_wdata,
   output logic [7:0]         io_rdata,
   output logic               cfg_open,
   output logic [15:0]        flash_io_base,
   output logic [2:0]         flash_seg_en,
   output logic               flash_lpc_wr_en,
   output logic               flash_pin_sel,
   output logic               flash_suspend,
   output logic [NUM_LDN-1:0] ldn_active
);
   if (NUM_LDN < 1 || NUM_LDN > 256) begin : g_bad_num
      $error("NUM_LDN must lie in 1..256");
   end
   if (FLASH_LDN < 0 || FLASH_LDN >= NUM_LDN) begin : g_bad_flash
      $error("FLASH_LDN must name an existing device");
   end
   if (BASE_LO == BASE_HI || KEY3_LO == KEY3_HI) begin : g_bad_base
      $error("the two bases and their keys must differ");
   end

   logic [15:0] own_base;
   logic        at_idx;
   logic        at_dat;
   logic [7:0]  idx_q;
   logic [7:0]  ldn_q;
   logic [7:0]  flags_q;
   logic        exit_req;
   logic        g_hit;
   logic [7:0]  g_val;
   logic        l_hit;
   logic [7:0]  l_val;
   logic [7:0]  dat_val;

   assign own_base = strap_alt_base ? BASE_HI : BASE_LO;
   assign at_idx   = (io_addr == own_base);
   assign at_dat   = (io_addr == own_base + 16'd1);

   cfgu_key_fsm #(.KEY3_LO(KEY3_LO), .KEY3_HI(KEY3_HI)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .alt_base (strap_alt_base),
      .byte_wr  (io_wr & at_idx & ~cfg_open),
      .byte_val (io_wdata),
      .exit_req (exit_req),
      .open_o   (cfg_open)
   );

   cfgu_global_regs #(.CHIP_ID(CHIP_ID)) u_glb (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_i   (cfg_open),
      .idx_wr   (io_wr & at_idx),
      .data_wr  (io_wr & at_dat),
      .wdata    (io_wdata),
      .idx_q    (idx_q),
      .ldn_q    (ldn_q),
      .flags_q  (flags_q),
      .exit_req (exit_req),
      .rd_hit   (g_hit),
      .rd_val   (g_val)
   );

   cfgu_ldn_bank #(
      .NUM_LDN   (NUM_LDN),
      .FLASH_LDN (FLASH_LDN),
      .FBASE_RST (FBASE_RST)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_i   (cfg_open),
      .data_wr  (io_wr & at_dat),
      .idx      (idx_q),
      .ldn      (ldn_q),
      .wdata    (io_wdata),
      .act_q    (ldn_active),
      .fbase_q  (flash_io_base),
      .rd_hit   (l_hit),
      .rd_val   (l_val)
   );

   always_comb begin
      if (g_hit)      dat_val = g_val;
      else if (l_hit) dat_val = l_val;
      else            dat_val = 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_rdata <= BUS_IDLE;
      end else if (io_rd) begin
         if (cfg_open && at_idx)      io_rdata <= idx_q;
         else if (cfg_open && at_dat) io_rdata <= dat_val;
         else                         io_rdata <= BUS_IDLE;
      end
   end

   assign flash_suspend   = flags_q[0];
   assign flash_seg_en    = flags_q[3:1];
   assign flash_lpc_wr_en = flags_q[4];
   assign flash_pin_sel   = flags_q[5];

   AST_LOCKED_READS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(io_rd && !cfg_open) |-> io_rdata == BUS_IDLE); // R3

   AST_FOREIGN_READS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(io_rd && !at_idx && !at_dat) |-> io_rdata == BUS_IDLE); // R4

   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(io_rd) |-> $stable(io_rdata)); // R11

   AST_BASE_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> $stable(flash_io_base)); // R3
endmodule

// File: tb/tb_cfgu_unlock_regfile.sv
module tb_cfgu_unlock_regfile;
   localparam int CLK_P = 10;
   localparam logic [15:0] FBASE_DEF = 16'h0820;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap = 1'b0;
   logic [15:0] io_addr = 16'h0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h0;
   logic [7:0]  io_rdata;
   logic        cfg_open;
   logic [15:0] flash_io_base;
   logic [2:0]  flash_seg_en;
   logic        flash_lpc_wr_en;
   logic        flash_pin_sel;
   logic        flash_suspend;
   logic [7:0]  ldn_active;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   cfgu_unlock_regfile dut (
      .clk(clk), .rst_n(rst_n), .strap_alt_base(strap),
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .cfg_open(cfg_open), .flash_io_base(flash_io_base),
      .flash_seg_en(flash_seg_en), .flash_lpc_wr_en(flash_lpc_wr_en),
      .flash_pin_sel(flash_pin_sel), .flash_suspend(flash_suspend),
      .ldn_active(ldn_active)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      d = io_rdata;
   endtask

   function automatic logic [15:0] base_of(input logic s);
      return s ? 16'h004E : 16'h002E;
   endfunction

   function automatic logic [7:0] key_of(input logic s);
      return s ? 8'hAA : 8'h55;
   endfunction

   task automatic unlock(input logic s);
      wr(base_of(s), 8'h87); wr(base_of(s), 8'h01);
      wr(base_of(s), 8'h55); wr(base_of(s), key_of(s));
   endtask

   task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
      wr(base_of(strap), i); wr(base_of(strap) + 16'd1, d);
   endtask

   task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
      wr(base_of(strap), i); rd(base_of(strap) + 16'd1, d);
   endtask

   task automatic do_reset(input logic s);
      @(negedge clk);
      rst_n = 1'b0; strap = s;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      for (int s = 0; s < 2; s++) begin
         do_reset(s[0]);
         check("R3 reset locked", cfg_open, 0);
         check("R8 reset base", flash_io_base, FBASE_DEF);
         rd(base_of(s[0]) + 16'd1, d);
         check("R3 locked data read", d, 8'hFF);
         rd(base_of(s[0]), d);
         check("R3 locked index read", d, 8'hFF);
         // wrong fourth byte (other strap's key)
         wr(base_of(s[0]), 8'h87); wr(base_of(s[0]), 8'h01);
         wr(base_of(s[0]), 8'h55); wr(base_of(s[0]), key_of(~s[0]));
         check("R1 wrong key3 stays locked", cfg_open, 0);
         // other base gets a full correct key for its own strap
         wr(base_of(~s[0]), 8'h87); wr(base_of(~s[0]), 8'h01);
         wr(base_of(~s[0]), 8'h55); wr(base_of(~s[0]), key_of(~s[0]));
         wr(base_of(~s[0]), key_of(s[0]));
         check("R4 foreign base key ignored", cfg_open, 0);
         // locked data write to flags, checked after unlock
         wr(base_of(s[0]), 8'h24); wr(base_of(s[0]) + 16'd1, 8'h3F);
         check("R3 locked write no flag", flash_suspend, 0);
         // broken stream: 87 01 87 01 55 key -> opens via restart
         wr(base_of(s[0]), 8'h87); wr(base_of(s[0]), 8'h01);
         wr(base_of(s[0]), 8'h87); wr(base_of(s[0]), 8'h01);
         wr(base_of(s[0]), 8'h55);
         check("R2 not yet open", cfg_open, 0);
         wr(base_of(s[0]), key_of(s[0]));
         check("R2 restart on 0x87 opens", cfg_open, 1);
         reg_rd(8'h24, d);
         check("R3 flags untouched while locked", d, 8'h00);
         rd(base_of(~s[0]) + 16'd1, d);
         check("R4 foreign data read", d, 8'hFF);
         wr(base_of(strap), 8'h21);
         rd(base_of(strap), d);
         check("R11 index readback", d, 8'h21);
         reg_wr(8'h02, 8'h01);
         check("R6 other exit value ignored", cfg_open, 1);
         reg_wr(8'h02, 8'h02);
         check("R6 exit closes", cfg_open, 0);
         rd(base_of(s[0]) + 16'd1, d);
         check("R3 data read after exit", d, 8'hFF);
         // 87 01 55 00 then key -> must not open
         wr(base_of(s[0]), 8'h87); wr(base_of(s[0]), 8'h01);
         wr(base_of(s[0]), 8'h55); wr(base_of(s[0]), 8'h00);
         wr(base_of(s[0]), key_of(s[0]));
         check("R2 mismatch restarts", cfg_open, 0);
         unlock(s[0]);
         check("R1 key opens", cfg_open, 1);
      end

      // strap 1 open here; ID registers
      reg_rd(8'h20, d); check("R5 id high", d, 8'h87);
      reg_rd(8'h21, d); check("R5 id low", d, 8'h16);
      reg_wr(8'h20, 8'h00);
      reg_rd(8'h20, d); check("R5 id read-only", d, 8'h87);
      reg_rd(8'h50, d); check("R11 unmapped reads zero", d, 8'h00);

      // flag sweep
      for (int v = 0; v < 256; v++) begin
         reg_wr(8'h24, 8'(v));
         check("R9 suspend", flash_suspend, v & 1);
         check("R9 seg", flash_seg_en, (v >> 1) & 7);
         check("R9 lpc", flash_lpc_wr_en, (v >> 4) & 1);
         check("R9 pin", flash_pin_sel, (v >> 5) & 1);
         reg_rd(8'h24, d);
         check("R9 readback", d, v & 8'h3F);
      end

      // device banks
      for (int g = 0; g < 8; g++) begin
         reg_wr(8'h07, 8'(g));
         reg_wr(8'h30, 8'(g & 1));
      end
      check("R10 activate vector", ldn_active, 8'hAA);
      for (int g = 0; g < 8; g++) begin
         reg_wr(8'h07, 8'(g));
         reg_rd(8'h07, d); check("R7 ldn readback", d, g);
         reg_rd(8'h30, d); check("R10 activate readback", d, g & 1);
      end

      reg_wr(8'h07, 8'h07);
      reg_wr(8'h64, 8'h12);
      reg_wr(8'h65, 8'h34);
      check("R8 flash base", flash_io_base, 16'h1234);
      reg_rd(8'h64, d); check("R8 base high read", d, 8'h12);
      reg_rd(8'h65, d); check("R8 base low read", d, 8'h34);
      reg_wr(8'h07, 8'h03);
      reg_wr(8'h64, 8'hFF);
      reg_wr(8'h65, 8'hEE);
      check("R8 other device ignored", flash_io_base, 16'h1234);
      reg_rd(8'h64, d); check("R8 other device reads zero", d, 8'h00);

      // relock then base stays put
      reg_wr(8'h02, 8'h02);
      wr(16'h004F, 8'h99);
      check("R3 base after relock", flash_io_base, 16'h1234);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule